// File: doc/BRIEF.md
# In-Order Retirement Queue with Speculative and Committed Register Files

This block keeps the instructions of an out-of-order core in their program order and lets them leave only in that order. A slot is claimed when an instruction is dispatched, and the returned slot index serves as the instruction's tag. When an execution unit finishes, it names that tag and supplies a result and an exception flag. The result lands in the slot and, at the same moment, in a speculative register file that later instructions can read.

The oldest slot leaves only once its result is present. A clean departure copies the result into a committed register file, so the committed file only ever changes in program order. If the departing instruction carries an exception, three things happen in one clock. Every slot is discarded. The committed file is not written. The whole committed file is loaded into the speculative file, which puts back the precise state. Execution units and exception vectoring sit outside the block.

Top module: `retire_queue`

## Requirements
- R1: After synchronous reset the queue is empty (`empty`=1, `full`=0), `ret_vld` is 0, and every register in both files reads 0.
- R2: `alloc_ok` is high exactly when `alloc_req` is high, the queue is not full, and no flush is happening in that cycle. `alloc_id` gives the tail slot, which steps 0,1,…,DEPTH-1 and then wraps to 0. A full queue refuses a request even in a cycle when the oldest slot retires.
- R3: A completion (`cmp_vld`, `cmp_id`) aimed at an occupied slot with no result yet marks that slot done. At the next edge it also writes `cmp_data` into the speculative register named by that slot's destination. A completion aimed at a free slot, or at a slot that is already done, changes nothing.
- R4: `ret_vld` is high, in the same cycle and combinationally, exactly when the oldest occupied slot is done. `ret_dst`, `ret_data` and `ret_exc` then describe that slot. A younger finished slot never retires ahead of it.
- R5: A retirement without exception writes `ret_data` into committed register `ret_dst` at that edge. The committed file changes at no other time.
- R6: A retirement with `ret_exc`=1 raises `flush` in that cycle. At the edge every slot is freed and the next `alloc_id` is 0. The committed file keeps its contents, and the speculative file becomes an exact copy of the committed file. Any completion offered in that cycle is dropped.
- R7: No allocation is accepted in a flush cycle.
- R8: At most one slot is claimed and at most one retires per cycle. `full` means DEPTH slots are occupied and `empty` means none is. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Request to claim a slot for a dispatched instruction |
| alloc_dst | input | 4 | Destination register of that instruction |
| alloc_ok | output | 1 | The request is accepted this cycle |
| alloc_id | output | 3 | Slot tag given to the accepted instruction |
| cmp_vld | input | 1 | An execution result is offered |
| cmp_id | input | 3 | Slot tag of the finishing instruction |
| cmp_data | input | 32 | Result value |
| cmp_exc | input | 1 | The finishing instruction raised an exception |
| ret_vld | output | 1 | The oldest slot retires at this edge |
| ret_dst | output | 4 | Destination register of the retiring slot |
| ret_data | output | 32 | Result of the retiring slot |
| ret_exc | output | 1 | The retiring slot carries an exception |
| flush | output | 1 | An exception retirement is discarding all slots this cycle |
| full | output | 1 | All slots occupied |
| empty | output | 1 | No slot occupied |
| fe_rd_idx | input | 4 | Read index into the speculative file |
| fe_rd_data | output | 32 | Speculative register value |
| ar_rd_idx | input | 4 | Read index into the committed file |
| ar_rd_data | output | 32 | Committed register value |

## Verification
The bench drives the queue full and then offers one more dispatch in the very cycle the oldest slot retires. A design that freed room through the retirement would accept that dispatch and take the wrong tag. It finishes a younger slot before the oldest one, which catches a design that retires whatever is done rather than only the head. It retires an exception while a dispatch and a completion are offered in the same cycle. A design that lets either through would hold a stale slot after the flush or would corrupt the restored speculative file. A random phase rich in exceptions, double completions and completions to free slots checks that the speculative file matches the committed file after every flush. A design with a bad copy or a wrongly placed committed write would show a mismatch on the swept read ports.

// File: rtl/rtq_pkg.sv
package rtq_pkg;
    parameter int unsigned DEPTH = 8;
    parameter int unsigned NREG  = 16;
    parameter int unsigned DW    = 32;

    localparam int unsigned IW = $clog2(DEPTH);
    localparam int unsigned RW = $clog2(NREG);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef logic [IW-1:0]           slot_t;
    typedef logic [RW-1:0]           reg_t;
    typedef logic [DW-1:0]           word_t;
    typedef logic [CW-1:0]           cnt_t;
    typedef logic [NREG-1:0][DW-1:0] file_t;

    typedef struct packed {
        logic  vld;
        logic  done;
        logic  exc;
        reg_t  dst;
        word_t val;
    } slot_s;

    function automatic slot_t slot_inc(slot_t p);
        return (p == slot_t'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction
endpackage

// File: rtl/rtq_ctrl.sv
module rtq_ctrl
    import rtq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  logic  push,
    input  logic  pop,
    output slot_t head,
    output slot_t tail,
    output logic  full,
    output logic  empty
);
    cnt_t count_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            head    <= '0;
            tail    <= '0;
            count_q <= '0;
        end else begin
            if (pop)  head <= slot_inc(head);
            if (push) tail <= slot_inc(tail);
            case ({push, pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    assign full  = (count_q == cnt_t'(DEPTH));
    assign empty = (count_q == '0);
endmodule

// File: rtl/rtq_slots.sv
module rtq_slots
    import rtq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  logic  push,
    input  slot_t push_idx,
    input  reg_t  push_dst,
    input  logic  pop,
    input  slot_t pop_idx,
    input  logic  cmp_vld,
    input  slot_t cmp_idx,
    input  word_t cmp_val,
    input  logic  cmp_exc,
    output logic  cmp_take,
    output reg_t  cmp_dst,
    output slot_s head_ent
);
    slot_s ent_q [DEPTH];

    assign cmp_take = cmp_vld && ent_q[cmp_idx].vld && !ent_q[cmp_idx].done;
    assign cmp_dst  = ent_q[cmp_idx].dst;
    assign head_ent = ent_q[pop_idx];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst || clear) begin
                ent_q[i] <= '0;
            end else if (push && push_idx == slot_t'(i)) begin
                ent_q[i] <= '{vld: 1'b1, done: 1'b0, exc: 1'b0, dst: push_dst, val: '0};
            end else if (pop && pop_idx == slot_t'(i)) begin
                ent_q[i] <= '0;
            end else if (cmp_take && cmp_idx == slot_t'(i)) begin
                ent_q[i].done <= 1'b1;
                ent_q[i].exc  <= cmp_exc;
                ent_q[i].val  <= cmp_val;
            end
        end
    end
endmodule

// File: rtl/rtq_regfile.sv
module rtq_regfile
    import rtq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  reg_t  wr_idx,
    input  word_t wr_val,
    input  logic  cpy_en,
    input  file_t cpy_src,
    input  reg_t  rd_idx,
    output word_t rd_val,
    output file_t all_q
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        word_t q;
        always_ff @(posedge clk) begin
            if (rst)                                q <= '0;
            else if (cpy_en)                        q <= cpy_src[g];
            else if (wr_en && wr_idx == reg_t'(g))  q <= wr_val;
        end
        assign all_q[g] = q;
    end

    assign rd_val = all_q[rd_idx];
endmodule

// File: rtl/retire_queue.sv
module retire_queue
    import rtq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  alloc_req,
    input  reg_t  alloc_dst,
    output logic  alloc_ok,
    output slot_t alloc_id,
    input  logic  cmp_vld,
    input  slot_t cmp_id,
    input  word_t cmp_data,
    input  logic  cmp_exc,
    output logic  ret_vld,
    output reg_t  ret_dst,
    output word_t ret_data,
    output logic  ret_exc,
    output logic  flush,
    output logic  full,
    output logic  empty,
    input  reg_t  fe_rd_idx,
    output word_t fe_rd_data,
    input  reg_t  ar_rd_idx,
    output word_t ar_rd_data
);
    slot_t head, tail;
    slot_s head_ent;
    logic  cmp_take;
    reg_t  cmp_dst;
    file_t fe_all, ar_all;

    assign ret_vld  = head_ent.vld && head_ent.done;
    assign ret_dst  = head_ent.dst;
    assign ret_data = head_ent.val;
    assign ret_exc  = head_ent.exc;
    assign flush    = ret_vld && head_ent.exc;
    assign alloc_ok = alloc_req && !full && !flush;
    assign alloc_id = tail;

    rtq_ctrl ctrl_i (
        .clk(clk), .rst(rst), .clear(flush),
        .push(alloc_ok), .pop(ret_vld),
        .head(head), .tail(tail), .full(full), .empty(empty)
    );

    rtq_slots slots_i (
        .clk(clk), .rst(rst), .clear(flush),
        .push(alloc_ok), .push_idx(tail), .push_dst(alloc_dst),
        .pop(ret_vld), .pop_idx(head),
        .cmp_vld(cmp_vld), .cmp_idx(cmp_id), .cmp_val(cmp_data), .cmp_exc(cmp_exc),
        .cmp_take(cmp_take), .cmp_dst(cmp_dst), .head_ent(head_ent)
    );

    rtq_regfile fe_file_i (
        .clk(clk), .rst(rst),
        .wr_en(cmp_take && !flush), .wr_idx(cmp_dst), .wr_val(cmp_data),
        .cpy_en(flush), .cpy_src(ar_all),
        .rd_idx(fe_rd_idx), .rd_val(fe_rd_data), .all_q(fe_all)
    );

    rtq_regfile ar_file_i (
        .clk(clk), .rst(rst),
        .wr_en(ret_vld && !head_ent.exc), .wr_idx(head_ent.dst), .wr_val(head_ent.val),
        .cpy_en(1'b0), .cpy_src('0),
        .rd_idx(ar_rd_idx), .rd_val(ar_rd_data), .all_q(ar_all)
    );
endmodule

// File: rtl/rtq_checker.sv
module rtq_checker
    import rtq_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  alloc_ok,
    input logic  full,
    input logic  empty,
    input logic  flush,
    input logic  ret_vld,
    input logic  ret_exc,
    input reg_t  ret_dst,
    input word_t ret_data,
    input file_t fe_all,
    input file_t ar_all
);
    assert_no_alloc_when_full_R2: assert property (@(posedge clk) disable iff (rst)
        full |-> !alloc_ok);

    assert_no_retire_when_empty_R4: assert property (@(posedge clk) disable iff (rst)
        empty |-> !ret_vld);

    assert_commit_write_R5: assert property (@(posedge clk) disable iff (rst)
        (ret_vld && !ret_exc) |=> ar_all[$past(ret_dst)] == $past(ret_data));

    assert_commit_stable_R5: assert property (@(posedge clk) disable iff (rst)
        !(ret_vld && !ret_exc) |=> $stable(ar_all));

    assert_flush_empties_R6: assert property (@(posedge clk) disable iff (rst)
        flush |=> empty);

    assert_flush_restores_R6: assert property (@(posedge clk) disable iff (rst)
        flush |=> fe_all == $past(ar_all));

    assert_flush_blocks_alloc_R7: assert property (@(posedge clk) disable iff (rst)
        flush |-> !alloc_ok);

    assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));
endmodule

bind retire_queue rtq_checker chk_i (
    .clk(clk), .rst(rst), .alloc_ok(alloc_ok), .full(full), .empty(empty),
    .flush(flush), .ret_vld(ret_vld), .ret_exc(ret_exc), .ret_dst(ret_dst),
    .ret_data(ret_data), .fe_all(fe_all), .ar_all(ar_all)
);

// File: tb/retire_queue_tb_top.sv
module retire_queue_tb_top;
    import rtq_pkg::*;

    logic  clk = 1'b0;
    logic  rst = 1'b1;
    logic  alloc_req = 1'b0;
    reg_t  alloc_dst = '0;
    logic  alloc_ok;
    slot_t alloc_id;
    logic  cmp_vld = 1'b0;
    slot_t cmp_id = '0;
    word_t cmp_data = '0;
    logic  cmp_exc = 1'b0;
    logic  ret_vld, ret_exc, flush, full, empty;
    reg_t  ret_dst;
    word_t ret_data, fe_rd_data, ar_rd_data;
    reg_t  fe_rd_idx = '0;
    reg_t  ar_rd_idx = '0;

    int checks = 0;
    int errors = 0;
    int rdp = 0;

    // behavioural reference: slot contents plus a program-order queue of slot ids
    int m_vld [DEPTH];
    int m_done [DEPTH];
    int m_exc [DEPTH];
    int m_dst [DEPTH];
    int m_val [DEPTH];
    int m_ord [$];
    int m_tail = 0;
    int m_fe [NREG];
    int m_ar [NREG];

    always #4 clk = ~clk;

    retire_queue dut_i (
        .clk(clk), .rst(rst), .alloc_req(alloc_req), .alloc_dst(alloc_dst),
        .alloc_ok(alloc_ok), .alloc_id(alloc_id), .cmp_vld(cmp_vld), .cmp_id(cmp_id),
        .cmp_data(cmp_data), .cmp_exc(cmp_exc), .ret_vld(ret_vld), .ret_dst(ret_dst),
        .ret_data(ret_data), .ret_exc(ret_exc), .flush(flush), .full(full), .empty(empty),
        .fe_rd_idx(fe_rd_idx), .fe_rd_data(fe_rd_data),
        .ar_rd_idx(ar_rd_idx), .ar_rd_data(ar_rd_data)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < DEPTH; i++) begin
            m_vld[i] = 0; m_done[i] = 0; m_exc[i] = 0; m_dst[i] = 0; m_val[i] = 0;
        end
        m_ord.delete();
        m_tail = 0;
    endtask

    // called just after a falling edge; ends just after the next falling edge
    task automatic do_cycle(input bit areq, input int adst, input bit cv,
                            input int cid, input int cdat, input bit cex);
        int h, fi, ai;
        bit exp_ret, exp_fl, exp_aok, hit;
        alloc_req = areq; alloc_dst = reg_t'(adst);
        cmp_vld = cv; cmp_id = slot_t'(cid); cmp_data = word_t'(cdat); cmp_exc = cex;
        fi = rdp % NREG; ai = (rdp + 5) % NREG; rdp++;
        fe_rd_idx = reg_t'(fi); ar_rd_idx = reg_t'(ai);
        #1;
        h       = (m_ord.size() > 0) ? m_ord[0] : 0;
        exp_ret = (m_ord.size() > 0) && (m_done[h] != 0);
        exp_fl  = exp_ret && (m_exc[h] != 0);
        exp_aok = areq && (m_ord.size() < DEPTH) && !exp_fl;
        hit     = cv && m_vld[cid] != 0 && m_done[cid] == 0 && !exp_fl;
        chk("R4 ret_vld", int'(ret_vld), int'(exp_ret));
        if (exp_ret) begin
            chk("R4 ret_dst", int'(ret_dst), m_dst[h]);
            chk("R4 ret_data", int'(ret_data), m_val[h]);
        end
        chk("R6 flush", int'(flush), int'(exp_fl));
        if (exp_fl && areq) chk("R7 alloc_ok during flush", int'(alloc_ok), 0);
        else                chk("R2 alloc_ok", int'(alloc_ok), int'(exp_aok));
        if (exp_aok) chk("R2 alloc_id", int'(alloc_id), m_tail);
        chk("R8 full", int'(full), int'(m_ord.size() == DEPTH));
        chk("R8 empty", int'(empty), int'(m_ord.size() == 0));
        chk("R3 speculative read", int'(fe_rd_data), m_fe[fi]);
        chk("R5 committed read", int'(ar_rd_data), m_ar[ai]);
        // advance the reference
        if (exp_fl) begin
            for (int r = 0; r < NREG; r++) m_fe[r] = m_ar[r];
            model_clear();
        end else begin
            if (exp_ret) begin
                m_ar[m_dst[h]] = m_val[h];
                m_vld[h] = 0; m_done[h] = 0;
                void'(m_ord.pop_front());
            end
            if (hit) begin
                m_done[cid] = 1; m_exc[cid] = int'(cex); m_val[cid] = cdat;
                m_fe[m_dst[cid]] = cdat;
            end
            if (exp_aok) begin
                m_vld[m_tail] = 1; m_done[m_tail] = 0; m_exc[m_tail] = 0;
                m_dst[m_tail] = adst; m_val[m_tail] = 0;
                m_ord.push_back(m_tail);
                m_tail = (m_tail + 1) % DEPTH;
            end
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int r = 0; r < NREG; r++) begin m_fe[r] = 0; m_ar[r] = 0; end
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        #1;
        chk("R1 empty after reset", int'(empty), 1);
        chk("R1 full after reset", int'(full), 0);
        chk("R1 ret_vld after reset", int'(ret_vld), 0);
        for (int r = 0; r < NREG; r++) begin
            fe_rd_idx = reg_t'(r); ar_rd_idx = reg_t'(r); #1;
            chk("R1 speculative zero", int'(fe_rd_data), 0);
            chk("R1 committed zero", int'(ar_rd_data), 0);
        end
        @(negedge clk);
        // R2/R8: fill every slot, then one more request is refused
        for (int i = 0; i < DEPTH; i++) do_cycle(1, i + 1, 0, 0, 0, 0);
        do_cycle(1, 9, 0, 0, 0, 0);
        // R4: a younger slot finishing does not retire
        do_cycle(0, 0, 1, 3, 32'h33, 0);
        do_cycle(0, 0, 0, 0, 0, 0);
        // R3: second completion of a finished slot is ignored
        do_cycle(0, 0, 1, 3, 32'h77, 0);
        // oldest finishes; next cycle it retires while a request hits a full queue (R2)
        do_cycle(0, 0, 1, 0, 32'hA0, 0);
        do_cycle(1, 12, 0, 0, 0, 0);
        // R6/R7: exception retirement with a dispatch and a completion in the same cycle
        do_cycle(0, 0, 1, 1, 32'hBAD, 1);
        do_cycle(1, 4, 1, 2, 32'h55, 0);
        // R6: after flush the tag restarts at 0; completion to a free slot is ignored (R3)
        do_cycle(1, 6, 1, 5, 32'h66, 0);
        do_cycle(0, 0, 0, 0, 0, 0);
        // random phases: dispatch-heavy, balanced, exception-heavy
        for (int c = 0; c < 3000; c++) begin
            int ph = c / 1000;
            bit a  = ($urandom % 4) < ((ph == 0) ? 3 : 2);
            bit v  = ($urandom % 4) < ((ph == 0) ? 1 : 3);
            bit e  = ($urandom % ((ph == 2) ? 6 : 40)) == 0;
            do_cycle(a, int'($urandom % NREG), v, int'($urandom % DEPTH), int'($urandom), e);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule